// File: doc/BRIEF.md
# Pin Function Multiplexer and Output Port

This block is a register-mapped general-purpose I/O port for 54 pins. Software selects a role for each pin through a 3-bit function field: plain input, plain output, or one of six alternate functions. Output levels are held in a per-pin output register. That register changes only through two kinds of strobe writes, one that sets bits and one that clears bits, so one agent can change some pins without reading first and disturbing the others. A read-only level view returns the pin inputs after a two-stage synchronizer.

The port sits on a small 32-bit register bus: a select, a write enable, a byte address, write data, registered read data and a ready flag. Toward the pads it drives output data, output enable, an alternate-active flag and a 3-bit alternate number for each pin. When a pin is set to an alternate role, its output data and output enable come from the matching alternate peripheral inputs. The alternate peripherals and the pads are outside the block.

Top module: `gpio_fsel_port`

## Requirements
- R1: After reset every function field is 0, the output register is all zero, and pin_out, pin_oe, pin_alt_en and bus_ready are all low.
- R2: Function fields are packed ten to a word. Pin p sits in the word at byte offset 4·(p div 10), bits 3·(p mod 10)+2 down to 3·(p mod 10). Six words cover the offsets 0x00 to 0x14. A read returns the last value written to each existing field. Bits 30 and 31, and the bits of nonexistent pins 54 to 59 in the word at 0x14, read as zero.
- R3: Function code 0 gives input (pin_oe low, pin_alt_en low) and code 1 gives output (pin_oe high, pin_out equal to the output register bit). Codes 4, 5, 6, 7, 3 and 2 select alternates 0, 1, 2, 3, 4 and 5: pin_alt_en is high, pin_alt_num[3p+2:3p] gives the alternate number a, and pin_out and pin_oe for pin p equal alt_dout[54a+p] and alt_doe[54a+p].
- R4: A write to 0x1C (pins 0 to 31, bit b is pin b) or 0x20 (bit b is pin 32+b) sets the output bit for every 1 in the data. Bits written as 0 leave their output bit unchanged.
- R5: A write to 0x28 (pins 0 to 31) or 0x2C (pins 32 to 53) clears the output bit for every 1 in the data. Bits written as 0 leave their output bit unchanged.
- R6: Reads of 0x34 (pins 0 to 31) and 0x38 (pins 32 to 53, in bits 0 to 21) return pin_in after two synchronizing flops.
- R7: Reads of the set and clear offsets return zero. Writes to the level offsets and to unmapped offsets (0x18, 0x24, 0x30, 0x3C) change nothing, and unmapped offsets read zero.
- R8: Bits 22 to 31 of the second bank read as zero in the level register and are ignored by the set and clear writes.
- R9: bus_ready is high in the cycle after every cycle with bus_sel high and low otherwise. Read data is valid while bus_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Access completed; read data valid |
| pin_in | input | 54 | Raw pin input levels |
| pin_out | output | 54 | Per-pin output data |
| pin_oe | output | 54 | Per-pin output enable |
| pin_alt_en | output | 54 | Pin is in an alternate role |
| pin_alt_num | output | 162 | Alternate number per pin, 3 bits each |
| alt_dout | input | 324 | Alternate output data, index 54·a+p |
| alt_doe | input | 324 | Alternate output enable, index 54·a+p |

## Verification
The bench sweeps all eight function codes across every pin. A design with the alternate order scrambled would route the wrong peripheral lane and would show it on pin_out and pin_oe. The partial last function word and the ten missing pins of the second bank are aimed at directly: a design that kept those bits would read back ones there after the bench writes all ones. A long random run of set and clear strobes against a bench model exposes any design that treats a zero bit as a write of the value, since that would wipe pins the strobe never named. Writes to the level and unmapped offsets are followed by readback of the outputs and function words, so a decoder that aliases those offsets onto real registers fails.

// File: rtl/gpio_fsel_port.sv
module gpio_fsel_port #(
  parameter int NPINS = 54
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_ready,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe,
  output logic [NPINS-1:0]      pin_alt_en,
  output logic [3*NPINS-1:0]    pin_alt_num,
  input  logic [6*NPINS-1:0]    alt_dout,
  input  logic [6*NPINS-1:0]    alt_doe
);
  localparam int NWORDS = (NPINS + 9) / 10;

  logic [2:0]       fsel_q [NPINS];
  logic [NPINS-1:0] out_q, sync1, sync2;
  logic [63:0]      set_pad, clr_pad, lev_pad;
  logic [31:0]      rd_next;

  wire wr      = bus_sel & bus_we;
  wire fsel_hit = (int'(bus_addr[7:2]) < NWORDS) && (bus_addr[1:0] == 2'b00);

  assign lev_pad = 64'(sync2);
  assign set_pad = !wr                ? 64'd0 :
                   bus_addr == 8'h1C  ? {32'd0, bus_wdata} :
                   bus_addr == 8'h20  ? {bus_wdata, 32'd0} : 64'd0;
  assign clr_pad = !wr                ? 64'd0 :
                   bus_addr == 8'h28  ? {32'd0, bus_wdata} :
                   bus_addr == 8'h2C  ? {bus_wdata, 32'd0} : 64'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) fsel_q[p] <= 3'd0;
      out_q     <= '0;
      sync1     <= '0;
      sync2     <= '0;
      bus_rdata <= '0;
      bus_ready <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      out_q <= (out_q | set_pad[NPINS-1:0]) & ~clr_pad[NPINS-1:0];
      if (wr && fsel_hit)
        for (int p = 0; p < NPINS; p++)
          if (p / 10 == int'(bus_addr[7:2]))
            fsel_q[p] <= bus_wdata[3*(p%10) +: 3];
      bus_rdata <= (bus_sel && !bus_we) ? rd_next : 32'd0;
      bus_ready <= bus_sel;
    end
  end

  always_comb begin
    rd_next = 32'd0;
    if (fsel_hit) begin
      for (int p = 0; p < NPINS; p++)
        if (p / 10 == int'(bus_addr[7:2]))
          rd_next[3*(p%10) +: 3] = fsel_q[p];
    end else if (bus_addr == 8'h34) begin
      rd_next = lev_pad[31:0];
    end else if (bus_addr == 8'h38) begin
      rd_next = lev_pad[63:32];
    end
  end

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      logic [2:0] code, num;
      logic       alt;
      code = fsel_q[p];
      alt  = code[2] | code[1];
      num  = code[2] ? {1'b0, code[1:0]} : (3'd7 - code);
      if (!alt) num = 3'd0;
      pin_alt_en[p]         = alt;
      pin_alt_num[3*p +: 3] = num;
      pin_out[p] = alt ? alt_dout[int'(num)*NPINS + p] : out_q[p];
      pin_oe[p]  = alt ? alt_doe[int'(num)*NPINS + p]  : (code == 3'd1);
    end
  end
endmodule

// File: rtl/gpio_fsel_port_chk.sv
module gpio_fsel_port_chk #(
  parameter int NPINS = 54
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             bus_ready,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] pin_alt_en,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] sync2
);
  logic [1:0] age;
  always_ff @(posedge clk)
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  wire wr = bus_sel && bus_we;

  assert_ready_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready);
  assert_output_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 8'h00 && bus_wdata[2:0] == 3'd1) |=> pin_oe[0]);
  assert_alt_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 8'h00 && bus_wdata[2:0] == 3'd4) |=> pin_alt_en[0]);
  assert_set_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 8'h1C && bus_wdata[0]) |=> out_q[0]);
  assert_clear_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 8'h28 && bus_wdata[0]) |=> !out_q[0]);
  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (sync2[0] == $past(pin_in[0], 2)));
endmodule

bind gpio_fsel_port gpio_fsel_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .pin_in(pin_in), .pin_oe(pin_oe), .pin_alt_en(pin_alt_en),
  .out_q(out_q), .sync2(sync2)
);

// File: tb/gpio_fsel_port_test.sv
module gpio_fsel_port_test;
  localparam int N = 54;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_ready;
  logic [N-1:0] pin_in = 0, pin_out, pin_oe, pin_alt_en;
  logic [3*N-1:0] pin_alt_num;
  logic [6*N-1:0] alt_dout, alt_doe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [2:0] m_fsel [N];
  logic [N-1:0] m_out;
  logic [31:0] lf = 32'h1D2C3B4A;

  always #2 clk = ~clk;

  gpio_fsel_port uut (.*);

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk("R9 ready after access", 256'(bus_ready), 256'(1));
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_word(int w);
    logic [31:0] r = 0;
    for (int p = 0; p < N; p++)
      if (p / 10 == w) r[3*(p%10) +: 3] = m_fsel[p];
    return r;
  endfunction

  task automatic check_pins(input string tag);
    logic [N-1:0] eo, eoe, ea;
    logic [3*N-1:0] en;
    for (int p = 0; p < N; p++) begin
      int c = int'(m_fsel[p]);
      int a = (c >= 4) ? c - 4 : 7 - c;
      ea[p] = (c >= 2);
      en[3*p +: 3] = ea[p] ? 3'(a) : 3'd0;
      eo[p]  = ea[p] ? alt_dout[a*N + p] : m_out[p];
      eoe[p] = ea[p] ? alt_doe[a*N + p] : (c == 1);
    end
    chk({tag, " pin_out"}, 256'(pin_out), 256'(eo));
    chk({tag, " pin_oe"}, 256'(pin_oe), 256'(eoe));
    chk({tag, " alt_en"}, 256'(pin_alt_en), 256'(ea));
    chk({tag, " alt_num"}, 256'(pin_alt_num), 256'(en));
  endtask

  task automatic write_word(int w, logic [31:0] d);
    wr(8'(4*w), d);
    for (int p = 0; p < N; p++)
      if (p / 10 == w) m_fsel[p] = d[3*(p%10) +: 3];
  endtask

  function automatic logic [31:0] step(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 6*N; i++) begin
      alt_dout[i] = (i % 3 == 0);
      alt_doe[i]  = (i % 5 < 2);
    end
    for (int p = 0; p < N; p++) m_fsel[p] = 0;
    m_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready low", 256'(bus_ready), 256'(0));
    check_pins("R1 reset");
    for (int w = 0; w < 6; w++) begin
      rd(8'(4*w), d);
      chk("R1 fsel zero", 256'(d), 256'(0));
    end

    // R2 random patterns, read back with masking
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < 6; w++) begin
        lf = step(lf); lf = step(lf);
        write_word(w, lf | 32'hC000_0000);
      end
    for (int w = 0; w < 6; w++) begin
      rd(8'(4*w), d);
      chk("R2 fsel readback", 256'(d), 256'(exp_word(w)));
    end
    check_pins("R3 mixed codes");

    // R3 sweep all codes on all pins, R2 partial word mask
    for (int c = 0; c < 8; c++) begin
      logic [31:0] rep = 32'hC000_0000;
      for (int i = 0; i < 10; i++) rep[3*i +: 3] = 3'(c);
      for (int w = 0; w < 6; w++) write_word(w, rep);
      check_pins("R3 code sweep");
      rd(8'h14, d);
      chk("R2 partial word", 256'(d), 256'(rep & 32'h0000_0FFF));
      rd(8'h08, d);
      chk("R2 full word", 256'(d), 256'(rep & 32'h3FFF_FFFF));
    end

    // all pins output for set/clear tests
    for (int w = 0; w < 6; w++) write_word(w, 32'h0924_9249);
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a;
      lf = step(lf); lf = step(lf); lf = step(lf);
      case (k % 4)
        0: a = 8'h1C;
        1: a = 8'h28;
        2: a = 8'h20;
        default: a = 8'h2C;
      endcase
      wr(a, lf);
      if (a == 8'h1C) m_out[31:0] = m_out[31:0] | lf;
      if (a == 8'h28) m_out[31:0] = m_out[31:0] & ~lf;
      if (a == 8'h20) m_out[N-1:32] = m_out[N-1:32] | lf[N-33:0];
      if (a == 8'h2C) m_out[N-1:32] = m_out[N-1:32] & ~lf[N-33:0];
      check_pins((k % 2 == 0) ? "R4 set strobe" : "R5 clear strobe");
    end

    // R7 set/clear read zero
    rd(8'h1C, d); chk("R7 set reads zero", 256'(d), 256'(0));
    rd(8'h2C, d); chk("R7 clear reads zero", 256'(d), 256'(0));

    // R8 missing pins in bank 1
    wr(8'h20, 32'hFFFF_FFFF);
    m_out[N-1:32] = '1;
    check_pins("R8 bank1 set all");
    wr(8'h2C, 32'hFFC0_0000);
    check_pins("R8 bank1 clear unused bits");
    pin_in = '1;
    repeat (3) @(negedge clk);
    rd(8'h38, d);
    chk("R8 level bank1 mask", 256'(d), 256'(32'h003F_FFFF));

    // R6 level patterns
    for (int k = 0; k < 8; k++) begin
      lf = step(lf);
      pin_in[31:0] = lf;
      lf = step(lf);
      pin_in[N-1:32] = lf[N-33:0];
      repeat (3) @(negedge clk);
      rd(8'h34, d);
      chk("R6 level bank0", 256'(d), 256'(pin_in[31:0]));
      rd(8'h38, d);
      chk("R6 level bank1", 256'(d), 256'({10'd0, pin_in[N-1:32]}));
    end

    // R7 writes to level and unmapped offsets ignored
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h38, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    check_pins("R7 ignored writes");
    rd(8'h00, d); chk("R7 fsel untouched", 256'(d), 256'(exp_word(0)));
    rd(8'h34, d); chk("R7 level unaffected", 256'(d), 256'(pin_in[31:0]));
    rd(8'h18, d); chk("R7 unmapped zero", 256'(d), 256'(0));
    rd(8'h3C, d); chk("R7 unmapped zero", 256'(d), 256'(0));

    // R9 ready drops when idle
    @(negedge clk);
    chk("R9 ready idle", 256'(bus_ready), 256'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule